// File: doc/BRIEF.md
# Three-Wire Serial Nine-Bit Frame Packer

This block feeds a display controller over a three-wire serial link that has no separate data/command pin. Every byte handed to it carries a tag saying whether it is a command or data. The block turns each tagged byte into a nine-bit word, with the tag bit first and the payload after it, and sends the words as one continuous bit sequence. It drives the serial clock, the data line and an active-low chip select, and it derives the serial clock from the system clock.

A burst is a run of words that ends with the word marked last. After that word the block appends padding words until the burst's total bit count is a multiple of eight. Each padding word is a command word that carries a parameterised opcode, chosen so that the controller ignores it. The upstream side uses a valid/ready handshake. If upstream holds back mid-burst, the serial clock stops at a word boundary and chip select stays low, so the bit sequence has no gaps.

Top module: `nbf_packer`

## Requirements
- R1: Each word is nine bits on `mosi`. The first bit is the tag: 0 when `in_is_data` was 0 (command) and 1 when it was 1 (data). The eight payload bits follow, most significant bit first.
- R2: Words follow one another with no extra bits between them, even when the next word arrives late. A late word only stretches the low phase of `sclk`.
- R3: After the word accepted with `in_last` high, N being the number of words in the burst, the block appends (8 − N mod 8) mod 8 padding words. Each is the tag 0 followed by `PAD_OPCODE`, so the burst length is a multiple of 8 bits.
- R4: The link uses mode 0. `sclk` is low whenever `cs_n` is high, and `mosi` does not change while `sclk` is high.
- R5: Within a word, every high phase of `sclk` lasts exactly `HALF_DIV` system cycles, and so does every low phase that is not waiting on input.
- R6: `cs_n` falls on the clock edge that accepts the first word, exactly `HALF_DIV` cycles before the first rising edge of `sclk`. It rises 2·`HALF_DIV` cycles after the final rising edge of `sclk`, which is one half period after the final falling edge.
- R7: `busy` is high from the edge that accepts the first word of a burst until the edge that releases `cs_n`, so it always equals the inverse of `cs_n`.
- R8: `in_ready` is high only when the block is idle or is waiting at a word boundary inside an unfinished burst. A word offered while another is shifting is taken exactly once, after the current word ends.
- R9: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Block takes the offered word on this edge |
| in_byte | input | 8 | Payload byte |
| in_is_data | input | 1 | 1 for data, 0 for command |
| in_last | input | 1 | Word ends the burst; padding follows |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Burst in progress |

## Verification
The hardest case to reach is the end of a burst whose word count covers every residue modulo eight, while the next upstream word sometimes arrives early and sometimes late. The bench sends bursts of 1 to 17 words. Some of these hold `in_valid` high ahead of each boundary, and the others insert idle gaps before each word so that the block parks at a boundary. For every burst the bench rebuilds the expected bit sequence, including the padding words, and compares it with the bits captured on each rising edge of `sclk`.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,   // chip select high, waiting for a first word
    SEQ_LOW,    // serial clock low half
    SEQ_HIGH,   // serial clock high half
    SEQ_GAP,    // word boundary, waiting for the next upstream word
    SEQ_TAIL    // final half period before chip select release
  } seq_state_t;

  // Number of padding words still owed for a given residue (modulo 8).
  function automatic logic [2:0] pad_words_owed(input logic [2:0] residue);
    return 3'(3'd0 - residue);
  endfunction

endpackage

// File: rtl/nbf_rst_sync.sv
module nbf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/nbf_half_tick.sv
module nbf_half_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/nbf_word_shifter.sv
module nbf_word_shifter #(
  parameter int          PAYLOAD_W  = 8,
  parameter logic [7:0]  PAD_OPCODE = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_user,
  input  logic                 user_tag,
  input  logic [PAYLOAD_W-1:0] user_byte,
  input  logic                 load_pad,
  input  logic                 shift,
  output logic                 mosi,
  output logic                 bit_last,
  output logic                 residue_zero
);

  localparam int WORD_BITS = PAYLOAD_W + 1;
  localparam int IW        = $clog2(WORD_BITS + 1);
  localparam logic [2:0] ADVANCE = 3'(WORD_BITS % 8);

  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [2:0]           res_q, res_d;
  logic                 load;

  assign load = load_user || load_pad;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    res_d = res_q;
    if (load_user) begin
      sh_d  = {user_tag, user_byte};
      idx_d = '0;
      res_d = res_q + ADVANCE;
    end else if (load_pad) begin
      sh_d  = {1'b0, PAYLOAD_W'(PAD_OPCODE)};
      idx_d = '0;
      res_d = res_q + ADVANCE;
    end else if (shift) begin
      sh_d  = {sh_q[WORD_BITS-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= IW'(WORD_BITS - 1);
      res_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
      res_q <= res_d;
    end
  end

  assign mosi         = sh_q[WORD_BITS-1];
  assign bit_last     = (idx_q == IW'(WORD_BITS - 1));
  assign residue_zero = (nbf_pkg::pad_words_owed(res_q) == 3'd0);

  // R2
  load_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> bit_last);

  // R1
  nine_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !bit_last);

  // R1
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load_user, load_pad, shift}) <= 1);

endmodule

// File: rtl/nbf_seq.sv
module nbf_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  input  logic tick,
  input  logic bit_last,
  input  logic residue_zero,
  output logic load_user,
  output logic load_pad,
  output logic shift,
  output logic run,
  output logic sclk,
  output logic cs_n,
  output logic busy
);

  import nbf_pkg::*;

  seq_state_t st_q, st_d;
  logic       sclk_q, sclk_d;
  logic       cs_q, cs_d;
  logic       last_q, last_d;

  assign in_ready = (st_q == SEQ_IDLE) || (st_q == SEQ_GAP);
  assign run      = (st_q == SEQ_LOW) || (st_q == SEQ_HIGH) || (st_q == SEQ_TAIL);

  always_comb begin
    st_d      = st_q;
    sclk_d    = sclk_q;
    cs_d      = cs_q;
    last_d    = last_q;
    load_user = 1'b0;
    load_pad  = 1'b0;
    shift     = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (in_valid) begin
        load_user = 1'b1;
        last_d    = in_last;
        cs_d      = 1'b0;
        st_d      = SEQ_LOW;
      end
      SEQ_GAP: if (in_valid) begin
        load_user = 1'b1;
        last_d    = in_last;
        st_d      = SEQ_LOW;
      end
      SEQ_LOW: if (tick) begin
        sclk_d = 1'b1;
        st_d   = SEQ_HIGH;
      end
      SEQ_HIGH: if (tick) begin
        sclk_d = 1'b0;
        if (!bit_last) begin
          shift = 1'b1;
          st_d  = SEQ_LOW;
        end else if (!last_q) begin
          st_d = SEQ_GAP;
        end else if (!residue_zero) begin
          load_pad = 1'b1;
          st_d     = SEQ_LOW;
        end else begin
          st_d = SEQ_TAIL;
        end
      end
      SEQ_TAIL: if (tick) begin
        cs_d = 1'b1;
        st_d = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      last_q <= last_d;
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign busy = (st_q != SEQ_IDLE);

  // R4
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R7
  busy_matches_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  // R8
  ready_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sclk);

  // R3
  padded_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(residue_zero));

endmodule

// File: rtl/nbf_packer.sv
module nbf_packer #(
  parameter int         HALF_DIV   = 3,
  parameter logic [7:0] PAD_OPCODE = 8'h5C
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  input  logic       in_last,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy
);

  localparam int PAYLOAD_W = 8;

  logic rst_n;
  logic tick, run;
  logic load_user, load_pad, shift;
  logic bit_last, residue_zero;

  nbf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  nbf_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  nbf_word_shifter #(.PAYLOAD_W(PAYLOAD_W), .PAD_OPCODE(PAD_OPCODE)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_user    (load_user),
    .user_tag     (in_is_data),
    .user_byte    (in_byte),
    .load_pad     (load_pad),
    .shift        (shift),
    .mosi         (mosi),
    .bit_last     (bit_last),
    .residue_zero (residue_zero)
  );

  nbf_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .tick         (tick),
    .bit_last     (bit_last),
    .residue_zero (residue_zero),
    .load_user    (load_user),
    .load_pad     (load_pad),
    .shift        (shift),
    .run          (run),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .busy         (busy)
  );

  // R4
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: tb/nbf_packer_test.sv
module nbf_packer_test;

  localparam int         H   = 3;
  localparam logic [7:0] PAD = 8'h5C;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_byte;
  logic       in_is_data;
  logic       in_last;
  logic       sclk, mosi, cs_n, busy;

  nbf_packer #(.HALF_DIV(H), .PAD_OPCODE(PAD)) uut (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc++;

  // expected and captured streams
  logic exp_bits [0:511];
  int   exp_len;
  logic got_bits [0:511];
  int   got_len;

  // monitor state
  bit   mon_on = 0;
  logic p_sclk, p_cs, p_mosi;
  int   rise_cyc, cs_fall_cyc, first_gap, tail_gap;
  int   hi_bad, idle_bad, mosi_bad, ready_bad, busy_bad;
  bit   cs_rise_seen;

  always @(negedge clk) begin
    if (mon_on) begin
      if (sclk && !p_sclk) begin
        if (!cs_n && got_len < 512) begin
          got_bits[got_len] = mosi;
          got_len++;
          if (got_len == 1) first_gap = cyc - cs_fall_cyc;
        end
        rise_cyc = cyc;
        if (in_ready) ready_bad++;
      end
      if (!sclk && p_sclk && (cyc - rise_cyc != H)) hi_bad++;
      if (sclk && p_sclk && mosi != p_mosi) mosi_bad++;
      if (cs_n && sclk) idle_bad++;
      if (!cs_n && p_cs) cs_fall_cyc = cyc;
      if (cs_n && !p_cs) begin
        cs_rise_seen = 1;
        tail_gap = cyc - rise_cyc;
      end
      if (busy != !cs_n) busy_bad++;
    end
    p_sclk = sclk;
    p_cs   = cs_n;
    p_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((seed * 53 + i * 71 + 19) & 255);
  endfunction

  function automatic logic tag_of(input int mode, input int seed, input int i);
    if (mode == 0) return (i != 0);          // command then data
    return 1'(((i * 5 + seed) >> 1) & 1);    // mixed tags
  endfunction

  task automatic run_burst(input int n, input int seed, input int mode,
                           input int stall);
    int npad, mism, first_bad;
    // build expected stream (R1, R3)
    exp_len = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = byte_of(seed, i);
      exp_bits[exp_len] = tag_of(mode, seed, i);
      exp_len++;
      for (int k = 7; k >= 0; k--) begin
        exp_bits[exp_len] = b[k];
        exp_len++;
      end
    end
    npad = (8 - (n % 8)) % 8;
    for (int p = 0; p < npad; p++) begin
      exp_bits[exp_len] = 1'b0;
      exp_len++;
      for (int k = 7; k >= 0; k--) begin
        exp_bits[exp_len] = PAD[k];
        exp_len++;
      end
    end
    // clear monitor
    got_len = 0; hi_bad = 0; idle_bad = 0; mosi_bad = 0;
    ready_bad = 0; busy_bad = 0; cs_rise_seen = 0;
    first_gap = -1; tail_gap = -1;
    // drive words
    for (int i = 0; i < n; i++) begin
      if (stall != 0) repeat (stall + (i % 4) * 7) @(negedge clk);
      @(negedge clk);
      in_valid   = 1'b1;
      in_byte    = byte_of(seed, i);
      in_is_data = tag_of(mode, seed, i);
      in_last    = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    while (!cs_rise_seen) @(negedge clk);
    // compare
    mism = 0; first_bad = -1;
    for (int j = 0; j < exp_len && j < got_len; j++)
      if (got_bits[j] !== exp_bits[j]) begin
        mism++;
        if (first_bad < 0) first_bad = j;
      end
    chk(got_len == exp_len, "R3", $sformatf("bit count n=%0d", n), got_len, exp_len);
    chk(got_len % 8 == 0, "R3", "byte aligned length", got_len % 8, 0);
    chk(mism == 0, (stall != 0) ? "R2" : "R1",
        $sformatf("stream mismatches n=%0d first at", n), first_bad, -1);
    chk(hi_bad == 0, "R5", "high phase width errors", hi_bad, 0);
    chk(first_gap == H, "R6", "cs fall to first rise", first_gap, H);
    chk(tail_gap == 2 * H, "R6", "last rise to cs rise", tail_gap, 2 * H);
    chk(idle_bad == 0 && mosi_bad == 0, "R4", "mode 0 violations",
        idle_bad + mosi_bad, 0);
    chk(busy_bad == 0, "R7", "busy vs cs mismatches", busy_bad, 0);
    chk(ready_bad == 0, "R8", "ready high at clock rise", ready_bad, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_is_data = 1'b0; in_last = 1'b0;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9
    chk(cs_n == 1'b1, "R9", "cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0, "R9", "sclk after reset", sclk, 0);
    chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    mon_on = 1;
    // every residue, words offered early (R8 taken once each)
    for (int n = 1; n <= 17; n++) run_burst(n, n * 3 + 1, 0, 0);
    // stalled boundaries with mixed tags (R2)
    for (int n = 1; n <= 9; n++) run_burst(n, n * 11 + 2, 1, 3);
    // idle state restored
    chk(cs_n == 1'b1 && busy == 1'b0, "R7", "idle after bursts", busy, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule